// File: doc/BRIEF.md
# Template-driven microcode field sequencer

The sequencer takes 64-bit field words from a field-decompression FIFO, one decoded field per word, and walks them under the control of a small microcode program. Each message opens with a presence-map word and a template-number word. The template number indexes a jump table that gives the start address of a routine, and the routine then decides field by field whether a word is taken from the input, whether a presence bit is tested, and whether the field is forwarded with an output identifier or dropped. The result is a stream of records of the form identifier, value and end-of-message.

Several messages may share one packet, and the last input word of a packet carries a last flag. When a message fails, the whole packet must be thrown away downstream, so the sequencer pulses an error flag and then discards the input words that remain in that packet. Both the microcode store and the jump table are zero at power-up and are loaded through a single write port. Each is a one-read, one-write synchronous memory that maps onto block RAM.

Top module: `fld_seq`

## Requirements
- R1: After reset, out_valid and out_err are low and in_ready is high, with the sequencer waiting for a presence-map word.
- R2: The first word of a message loads its low PMAP_BITS bits (default 14) as the presence map, and tests take bits starting at bit PMAP_BITS-1 and moving downward. Bits past the end read as 0. The second word is the template number. A jump-table entry holds a valid flag in bit UAW (default 6) and the routine start address in bits UAW-1:0.
- R3: An instruction word has the opcode in [1:0] (0 end, 1 field, 2 jump, 3 branch-on-clear-presence-bit), optional in [2], forward in [3], constant in [4], output ID in [12:5] and target in [18:13]. A non-constant present field takes one input word. It emits a record (ID, word) only when forward is set, and otherwise emits nothing.
- R4: An optional field uses up one presence bit. When that bit is 0, the field is absent: no input word is taken and no record is emitted.
- R5: A present constant field takes no input word. With forward set, it emits a record whose value is the zero-extended target field.
- R6: A jump instruction continues at the target address. A branch instruction uses up one presence bit and goes to the target when the bit is 0, or to the next address when the bit is 1.
- R7: An end instruction emits one record with out_eom=1, ID 0 and value 0. The next input word is then read as the presence map of the next message.
- R8: A template number whose jump-table entry is not valid, or whose value is 2^TW or more (default 16), pulses out_err. Any further words of the packet up to and including the last word are dropped without records.
- R9: A packet that ends on its presence-map word pulses out_err. A field that needs an input word after the packet's last word has been taken also pulses out_err. In both cases the next word is a new presence map.
- R10: When cfg_we is high, cfg_wdata is written into the microcode store at cfg_addr if cfg_tbl=0, or into the jump table at cfg_addr if cfg_tbl=1. Later messages use the new contents.
- R11: An out_err pulse is never in the same cycle as a record, and while words are being dropped no record is emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Field word available |
| in_data | input | 64 | Decoded field word |
| in_last | input | 1 | Word is the last of its packet |
| in_ready | output | 1 | Word taken at this edge when in_valid is high |
| cfg_we | input | 1 | Store write strobe |
| cfg_tbl | input | 1 | 0 selects microcode, 1 selects jump table |
| cfg_addr | input | 6 | Store write address |
| cfg_wdata | input | 19 | Store write data |
| out_valid | output | 1 | Record valid |
| out_id | output | 8 | Record field identifier |
| out_value | output | 64 | Record field value |
| out_eom | output | 1 | Record marks end of message |
| out_err | output | 1 | Packet error pulse |

## Verification
The main stimulus is one routine run twice, once with its presence bits set and once with them clear. Comparing the two runs shows whether optional fields, branches and discarded fields take input words only when they should. A second template, made up only of a jump and an optional constant, shows that a constant uses no input and obeys its presence bit, and it also places two messages in a single packet. Error patterns cover an unmapped template number, an out-of-range number whose low bits hit a valid entry, a packet truncated in the middle of a routine, and a packet that holds only a presence map. After each of these a clean message follows, which shows that the sequencer has resynchronised. A final jump-table rewrite checks that configuration takes effect at run time.

// File: rtl/fs_pkg.sv
package fs_pkg;
  typedef enum logic [1:0] {
    OP_END = 2'd0,
    OP_FLD = 2'd1,
    OP_JMP = 2'd2,
    OP_BPM = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    S_PMAP  = 3'd0,
    S_TID   = 3'd1,
    S_LOOK  = 3'd2,
    S_FETCH = 3'd3,
    S_EXEC  = 3'd4,
    S_POP   = 3'd5,
    S_DROP  = 3'd6
  } st_e;
endpackage

// File: rtl/fs_store.sv
module fs_store #(
  parameter int W  = 19,
  parameter int AW = 6,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/fs_pmap.sv
module fs_pmap #(
  parameter int PB = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [PB-1:0] load_val,
  input  logic          shift,
  output logic          bit_o
);
  logic [PB-1:0] bits_q;

  always_ff @(posedge clk) begin
    if (rst)        bits_q <= '0;
    else if (load)  bits_q <= load_val;
    else if (shift) bits_q <= {bits_q[PB-2:0], 1'b0};
  end

  assign bit_o = bits_q[PB-1];
endmodule

// File: rtl/fld_seq.sv
module fld_seq #(
  parameter int DW        = 64,
  parameter int IDW       = 8,
  parameter int UAW       = 6,
  parameter int TW        = 4,
  parameter int PMAP_BITS = 14,
  localparam int IW  = 5 + IDW + UAW,
  localparam int JW  = UAW + 1,
  localparam int CAW = (UAW > TW) ? UAW : TW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [DW-1:0]  in_data,
  input  logic           in_last,
  output logic           in_ready,
  input  logic           cfg_we,
  input  logic           cfg_tbl,
  input  logic [CAW-1:0] cfg_addr,
  input  logic [IW-1:0]  cfg_wdata,
  output logic           out_valid,
  output logic [IDW-1:0] out_id,
  output logic [DW-1:0]  out_value,
  output logic           out_eom,
  output logic           out_err
);
  import fs_pkg::*;

  st_e            state;
  logic [UAW-1:0] ip;
  logic           seen_last;
  logic           tid_bad;
  logic [IW-1:0]  instr;
  logic [JW-1:0]  jt_q;
  logic           pm_bit;

  fs_store #(.W(IW), .AW(UAW)) u_code (
    .clk(clk), .we(cfg_we && !cfg_tbl), .waddr(cfg_addr[UAW-1:0]),
    .wdata(cfg_wdata), .raddr(ip), .rdata(instr));

  fs_store #(.W(JW), .AW(TW)) u_jump (
    .clk(clk), .we(cfg_we && cfg_tbl), .waddr(cfg_addr[TW-1:0]),
    .wdata(cfg_wdata[JW-1:0]), .raddr(in_data[TW-1:0]), .rdata(jt_q));

  op_e            i_op;
  logic           i_opt, i_fwd, i_cst, present, pm_test;
  logic [IDW-1:0] i_id;
  logic [UAW-1:0] i_tgt;

  assign i_op    = op_e'(instr[1:0]);
  assign i_opt   = instr[2];
  assign i_fwd   = instr[3];
  assign i_cst   = instr[4];
  assign i_id    = instr[5 +: IDW];
  assign i_tgt   = instr[5 + IDW +: UAW];
  assign present = !i_opt || pm_bit;
  assign pm_test = (state == S_EXEC) &&
                   ((i_op == OP_BPM) || ((i_op == OP_FLD) && i_opt));

  fs_pmap #(.PB(PMAP_BITS)) u_pmap (
    .clk(clk), .rst(rst), .load((state == S_PMAP) && in_valid),
    .load_val(in_data[PMAP_BITS-1:0]), .shift(pm_test), .bit_o(pm_bit));

  assign in_ready = (state == S_PMAP) || (state == S_TID) || (state == S_DROP) ||
                    ((state == S_POP) && !seen_last);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_PMAP;
      ip        <= '0;
      seen_last <= 1'b0;
      tid_bad   <= 1'b0;
      out_valid <= 1'b0;
      out_id    <= '0;
      out_value <= '0;
      out_eom   <= 1'b0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_eom   <= 1'b0;
      out_err   <= 1'b0;
      case (state)
        S_PMAP: if (in_valid) begin
          if (in_last) out_err <= 1'b1;
          else         state   <= S_TID;
        end
        S_TID: if (in_valid) begin
          seen_last <= in_last;
          tid_bad   <= |in_data[DW-1:TW];
          state     <= S_LOOK;
        end
        S_LOOK: begin
          if (tid_bad || !jt_q[UAW]) begin
            out_err   <= 1'b1;
            seen_last <= 1'b0;
            state     <= seen_last ? S_PMAP : S_DROP;
          end else begin
            ip    <= jt_q[UAW-1:0];
            state <= S_FETCH;
          end
        end
        S_FETCH: state <= S_EXEC;
        S_EXEC: begin
          case (i_op)
            OP_END: begin
              out_valid <= 1'b1;
              out_eom   <= 1'b1;
              out_id    <= '0;
              out_value <= '0;
              seen_last <= 1'b0;
              state     <= S_PMAP;
            end
            OP_JMP: begin
              ip    <= i_tgt;
              state <= S_FETCH;
            end
            OP_BPM: begin
              ip    <= pm_bit ? ip + 1'b1 : i_tgt;
              state <= S_FETCH;
            end
            default: begin
              if (present && !i_cst) begin
                state <= S_POP;
              end else begin
                if (present && i_fwd) begin
                  out_valid <= 1'b1;
                  out_id    <= i_id;
                  out_value <= {{(DW-UAW){1'b0}}, i_tgt};
                end
                ip    <= ip + 1'b1;
                state <= S_FETCH;
              end
            end
          endcase
        end
        S_POP: begin
          if (seen_last) begin
            out_err   <= 1'b1;
            seen_last <= 1'b0;
            state     <= S_PMAP;
          end else if (in_valid) begin
            if (i_fwd) begin
              out_valid <= 1'b1;
              out_id    <= i_id;
              out_value <= in_data;
            end
            seen_last <= in_last;
            ip        <= ip + 1'b1;
            state     <= S_FETCH;
          end
        end
        S_DROP: if (in_valid && in_last) state <= S_PMAP;
        default: state <= S_PMAP;
      endcase
    end
  end
endmodule

// File: rtl/fs_chk.sv
module fs_chk #(
  parameter int DW  = 64,
  parameter int IDW = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           out_valid,
  input logic           out_eom,
  input logic           out_err,
  input logic [IDW-1:0] out_id,
  input logic [DW-1:0]  out_value,
  input fs_pkg::st_e    st
);
  import fs_pkg::*;

  AST_EOM_SHAPE: assert property (@(posedge clk) disable iff (rst)
    out_eom |-> (out_valid && out_id == '0 && out_value == '0)); // R7

  AST_ERR_NO_RECORD: assert property (@(posedge clk) disable iff (rst)
    out_err |-> !out_valid); // R11

  AST_ERR_RESYNC: assert property (@(posedge clk) disable iff (rst)
    out_err |-> (st == S_PMAP || st == S_DROP)); // R8

  AST_DROP_QUIET: assert property (@(posedge clk) disable iff (rst)
    (st == S_DROP) |=> !out_valid); // R11

  AST_EOM_TO_PMAP: assert property (@(posedge clk) disable iff (rst)
    out_eom |-> (st == S_PMAP)); // R7
endmodule

bind fld_seq fs_chk #(.DW(DW), .IDW(IDW)) u_chk (
  .clk(clk), .rst(rst), .out_valid(out_valid), .out_eom(out_eom),
  .out_err(out_err), .out_id(out_id), .out_value(out_value), .st(state));

// File: tb/tb_fld_seq.sv
`timescale 1ns/1ps
module tb_fld_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] in_data = '0;
  logic        in_last = 1'b0;
  logic        in_ready;
  logic        cfg_we = 1'b0;
  logic        cfg_tbl = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [18:0] cfg_wdata = '0;
  logic        out_valid;
  logic [7:0]  out_id;
  logic [63:0] out_value;
  logic        out_eom;
  logic        out_err;

  int vectors = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  fld_seq dut (.*);

  typedef struct {
    bit err; bit eom; int id; longint unsigned val; string tag;
  } rec_t;
  rec_t exq[$];

  task automatic exp_rec(int id, longint unsigned v, string t);
    rec_t r; r.err = 0; r.eom = 0; r.id = id; r.val = v; r.tag = t; exq.push_back(r);
  endtask
  task automatic exp_eom(string t);
    rec_t r; r.err = 0; r.eom = 1; r.id = 0; r.val = 0; r.tag = t; exq.push_back(r);
  endtask
  task automatic exp_err(string t);
    rec_t r; r.err = 1; r.eom = 0; r.id = 0; r.val = 0; r.tag = t; exq.push_back(r);
  endtask

  always @(negedge clk) begin
    if (!rst && (out_valid || out_err)) begin
      vectors++;
      if (exq.size() == 0) begin
        fails++;
        $display("FAIL unexpected output: valid=%0b err=%0b id=%0d value=%0h expected nothing",
                 out_valid, out_err, out_id, out_value);
      end else begin
        rec_t e;
        e = exq.pop_front();
        if (out_err != e.err || (!e.err && (out_valid != 1'b1 || out_eom != e.eom ||
            out_id != e.id[7:0] || out_value != e.val))) begin
          fails++;
          $display("FAIL %s: actual err=%0b eom=%0b id=%0d value=%0h expected err=%0b eom=%0b id=%0d value=%0h",
                   e.tag, out_err, out_eom, out_id, out_value, e.err, e.eom, e.id, e.val);
        end
      end
    end
  end

  task automatic send(logic [63:0] d, logic l);
    in_valid = 1'b1; in_data = d; in_last = l;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic cfg(logic tbl, logic [5:0] a, logic [18:0] d);
    cfg_we = 1'b1; cfg_tbl = tbl; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [18:0] ins(int op, bit opt, bit fwd, bit cst, int id, int tgt);
    return (19'(tgt) << 13) | (19'(id) << 5) | (19'(cst) << 4) | (19'(fwd) << 3) |
           (19'(opt) << 2) | 19'(op);
  endfunction

  task automatic drain(string t);
    repeat (20) @(negedge clk);
    vectors++;
    if (exq.size() != 0) begin
      fails++;
      $display("FAIL %s: %0d records missing, expected 0", t, exq.size());
      exq.delete();
    end
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    vectors++;
    if (out_valid || out_err || !in_ready) begin
      fails++;
      $display("FAIL R1: valid=%0b err=%0b ready=%0b expected 0 0 1", out_valid, out_err, in_ready);
    end

    // R10: load program through the configuration port
    cfg(0, 0,  ins(1, 0, 1, 0, 10, 0));
    cfg(0, 1,  ins(1, 1, 1, 0, 11, 0));
    cfg(0, 2,  ins(1, 0, 1, 1, 12, 5));
    cfg(0, 3,  ins(1, 0, 0, 0, 0, 0));
    cfg(0, 4,  ins(3, 0, 0, 0, 0, 6));
    cfg(0, 5,  ins(1, 0, 1, 0, 13, 0));
    cfg(0, 6,  ins(0, 0, 0, 0, 0, 0));
    cfg(0, 8,  ins(2, 0, 0, 0, 0, 10));
    cfg(0, 9,  ins(1, 0, 1, 0, 99, 0));
    cfg(0, 10, ins(1, 1, 1, 1, 20, 7));
    cfg(0, 11, ins(0, 0, 0, 0, 0, 0));
    cfg(0, 12, ins(0, 0, 0, 0, 0, 0));
    cfg(1, 3, 19'd64);
    cfg(1, 5, 19'd72);
    cfg(1, 1, 19'd76);

    // R2 R3 R4 R6: template 3 with both presence bits set
    exp_rec(10, 64'h111, "R3 mandatory forward");
    exp_rec(11, 64'h222, "R4 optional present");
    exp_rec(12, 64'd5,   "R5 constant value");
    exp_rec(13, 64'h444, "R6 branch bit set");
    exp_eom("R7 end A");
    send(64'h3000, 0); send(64'd3, 0); send(64'h111, 0); send(64'h222, 0);
    send(64'h333, 0); send(64'h444, 1);
    drain("R3 test A");

    // R4 R6: template 3 with presence bits clear
    exp_rec(10, 64'hA1, "R4 absent skip");
    exp_rec(12, 64'd5,  "R5 constant B");
    exp_eom("R6 branch taken");
    send(64'h0, 0); send(64'd3, 0); send(64'hA1, 0); send(64'hC3, 1);
    drain("R4 test B");

    // R5 R6 R7: two messages in one packet
    exp_rec(20, 64'd7, "R5 optional constant present");
    exp_eom("R7 first message");
    exp_eom("R7 second message");
    send(64'h2000, 0); send(64'd5, 0); send(64'h0, 0); send(64'd1, 1);
    drain("R7 test C");

    // R5: optional constant absent
    exp_eom("R5 optional constant absent");
    send(64'h0, 0); send(64'd5, 1);
    drain("R5 test D");

    // R8 R11: unmapped template, drop rest
    exp_err("R8 unmapped template");
    send(64'h0, 0); send(64'd2, 0); send(64'h55, 0); send(64'h66, 0); send(64'h77, 1);
    drain("R11 drop silent");
    exp_eom("R8 recovery");
    send(64'h0, 0); send(64'd5, 1);
    drain("R8 recovery drain");

    // R8: out-of-range template number with valid low bits
    exp_err("R8 template range");
    send(64'h0, 0); send(64'h13, 1);
    exp_eom("R8 range recovery");
    send(64'h0, 0); send(64'd5, 1);
    drain("R8 test G");

    // R9: truncated message
    exp_rec(10, 64'hBEEF, "R9 before truncation");
    exp_err("R9 truncation");
    send(64'h3000, 0); send(64'd3, 0); send(64'hBEEF, 1);
    drain("R9 test H");

    // R9: presence-map-only packet
    exp_err("R9 pmap only");
    send(64'h1234, 1);
    exp_eom("R9 recovery");
    send(64'h0, 0); send(64'd5, 1);
    drain("R9 test I");

    // R10: remap template 2 at run time
    cfg(1, 2, 19'd76);
    exp_eom("R10 remapped template");
    send(64'h0, 0); send(64'd2, 1);
    drain("R10 test J");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule